// File: doc/BRIEF.md
# Multi-Channel Poll Scheduler with Retries

This block walks through eight temperature channels (four sockets with two domains each) and reads each enabled channel in turn through an abstract serial-read engine. It issues one read at a time over a request/done/error handshake. After a failed read it tries again, up to a programmed retry limit. Between two reads it always leaves a fixed minimum gap. After a full pass it waits for a coded pause before it starts the next pass.

When the pause code is zero or seven, the block runs only on request. In that mode a request strobe starts exactly one pass. For each channel it keeps either the last good reading or a state: never polled since reset, or retries used up. A query port returns the stored value, or a 16-bit error code when the channel is disabled, not yet polled, or failed. Time is measured with a 500 µs tick input, so 2.5 ms is five ticks.

Top module: `poll_sched`

## Requirements
- R1: Bit i of `en_mask_i` enables channel i, where channel i is socket i/2, domain i%2. A pass reads only the enabled channels, in ascending channel order, and reports the channel number on `rd_ch_o`.
- R2: Only one read is outstanding at a time. `rd_req_o` stays high with `rd_ch_o` stable until `rd_done_i`, and it is low whenever `busy_o` is low.
- R3: A read request is not raised until at least 5 ticks have passed since the previous read completed. This also applies to retries.
- R4: With retry limit L, a channel is tried at most L+1 times in one pass. A read that completes without error ends the retries for that channel.
- R5: A channel whose last pass used up all its attempts reads back 16'h8100 on the query port.
- R6: A channel whose mask bit is 0 reads back 16'h8101, even if data was stored for it earlier.
- R7: An enabled channel that has not finished a poll since reset reads back 16'h8102. Once a poll has finished, the channel never returns to that state.
- R8: An enabled channel whose last poll succeeded reads back the 16-bit word taken from `rd_data_i`, unchanged.
- R9: Pause code on `dly_code_i` maps to the wait after each pass as follows: 1 = 5 ticks, 2 = 10, 3 = 20, 4 = 100, 5 = 200, 6 = 1000. The next pass starts by itself after that wait.
- R10: Pause codes 0 and 7 select request-only mode. No pass starts by itself, and a one-cycle pulse on `poll_req_i` while idle starts exactly one pass.
- R11: A pulse on `poll_req_i` while a pass is running (`busy_o` high) is ignored and does not cause an extra pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle 500 µs time-base pulse |
| en_mask_i | input | 8 | Per-channel enable mask |
| dly_code_i | input | 3 | Pause code applied after each pass |
| retry_lim_i | input | 8 | Number of retries allowed after a failed read |
| poll_req_i | input | 1 | Strobe that starts one pass |
| rd_req_o | output | 1 | Read request to the serial engine |
| rd_ch_o | output | 3 | Channel to read |
| rd_done_i | input | 1 | Read finished, one-cycle pulse |
| rd_err_i | input | 1 | Read failed, valid with `rd_done_i` |
| rd_data_i | input | 16 | Read result, valid with `rd_done_i` |
| qry_ch_i | input | 3 | Channel to query |
| qry_data_o | output | 16 | Stored reading or error code for `qry_ch_i` |
| busy_o | output | 1 | A pass is in progress |

## Verification
Three masks are tried: a sparse mask (channels 0, 2, 5), a single-channel mask and an all-enabled mask. The sparse mask separates correct ascending selection from reads of disabled channels. The engine model is made to fail a chosen number of times per channel. This separates recovery before the limit from exhaustion at the limit, and covers the edge case of a zero retry limit. The pause codes 1, 4, 6 and 7 are run with a slow tick, so the measured wait tells a correct table entry from its neighbours. A request pulse in the middle of a pass checks that no extra pass follows.

// File: rtl/poll_pkg.sv
package poll_pkg;
  localparam logic [15:0] ERR_RETRY = 16'h8100;
  localparam logic [15:0] ERR_OFF   = 16'h8101;
  localparam logic [15:0] ERR_FIRST = 16'h8102;
  localparam int GAP_TICKS = 5;
  localparam int PAUSE_W   = 11;

  typedef enum logic [1:0] {CS_NONE, CS_OK, CS_FAIL} ch_st_e;
  typedef enum logic [1:0] {PS_IDLE, PS_SCAN, PS_READ} ps_e;

  // pause length in 500 us ticks; 0 = request-only
  function automatic logic [PAUSE_W-1:0] pause_ticks(input logic [2:0] code);
    case (code)
      3'd1:    return 11'd5;
      3'd2:    return 11'd10;
      3'd3:    return 11'd20;
      3'd4:    return 11'd100;
      3'd5:    return 11'd200;
      3'd6:    return 11'd1000;
      default: return 11'd0;
    endcase
  endfunction
endpackage

// File: rtl/poll_timer.sv
module poll_timer #(
  parameter int GAP_TICKS = 5,
  parameter int PAUSE_W   = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               rd_fin_i,
  input  logic               pause_load_i,
  input  logic [PAUSE_W-1:0] pause_val_i,
  output logic               gap_ok_o,
  output logic               pause_zero_o
);
  localparam int GAP_W = $clog2(GAP_TICKS + 1);

  logic [GAP_W-1:0]   gap_q;
  logic [PAUSE_W-1:0] pause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q <= GAP_W'(GAP_TICKS);
    end else if (rd_fin_i) begin
      gap_q <= '0;
    end else if (tick_i && gap_q != GAP_W'(GAP_TICKS)) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pause_q <= '0;
    end else if (pause_load_i) begin
      pause_q <= pause_val_i;
    end else if (tick_i && pause_q != '0) begin
      pause_q <= pause_q - 1'b1;
    end
  end

  assign gap_ok_o     = (gap_q == GAP_W'(GAP_TICKS));
  assign pause_zero_o = (pause_q == '0);

  // R3
  gap_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_fin_i |=> !gap_ok_o);
endmodule

// File: rtl/poll_chan_store.sv
module poll_chan_store
  import poll_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 16,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CH_W-1:0]   wr_ch_i,
  input  logic              wr_fail_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [NUM_CH-1:0] en_mask_i,
  input  logic [CH_W-1:0]   qry_ch_i,
  output logic [DATA_W-1:0] qry_data_o
);
  ch_st_e            st_q  [NUM_CH];
  logic [DATA_W-1:0] dat_q [NUM_CH];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q[i]  <= CS_NONE;
        dat_q[i] <= '0;
      end else if (wr_en_i && wr_ch_i == CH_W'(i)) begin
        st_q[i] <= wr_fail_i ? CS_FAIL : CS_OK;
        if (!wr_fail_i) dat_q[i] <= wr_data_i;
      end
    end

    // R7
    first_poll_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q[i] != CS_NONE) |=> (st_q[i] != CS_NONE));
  end

  always_comb begin
    if (!en_mask_i[qry_ch_i]) begin
      qry_data_o = DATA_W'(ERR_OFF);
    end else begin
      case (st_q[qry_ch_i])
        CS_OK:   qry_data_o = dat_q[qry_ch_i];
        CS_FAIL: qry_data_o = DATA_W'(ERR_RETRY);
        default: qry_data_o = DATA_W'(ERR_FIRST);
      endcase
    end
  end
endmodule

// File: rtl/poll_sched.sv
module poll_sched
  import poll_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int DATA_W  = 16,
  parameter int RETRY_W = 8,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int PTR_W  = CH_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [NUM_CH-1:0]  en_mask_i,
  input  logic [2:0]         dly_code_i,
  input  logic [RETRY_W-1:0] retry_lim_i,
  input  logic               poll_req_i,
  output logic               rd_req_o,
  output logic [CH_W-1:0]    rd_ch_o,
  input  logic               rd_done_i,
  input  logic               rd_err_i,
  input  logic [DATA_W-1:0]  rd_data_i,
  input  logic [CH_W-1:0]    qry_ch_i,
  output logic [DATA_W-1:0]  qry_data_o,
  output logic               busy_o
);
  ps_e                state_q;
  logic [PTR_W-1:0]   ptr_q;
  logic [RETRY_W-1:0] try_q;
  logic               req_q;
  logic               gap_ok, pause_zero, auto_mode;
  logic               rd_fin, pass_end, last_try, wr_en;
  logic [PAUSE_W-1:0] pause_val;

  assign pause_val = pause_ticks(dly_code_i);
  assign auto_mode = (pause_val != '0);
  assign pass_end  = (state_q == PS_SCAN) && (ptr_q == PTR_W'(NUM_CH));
  assign rd_fin    = (state_q == PS_READ) && rd_done_i;
  assign last_try  = (try_q == retry_lim_i);
  assign wr_en     = rd_fin && (!rd_err_i || last_try);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PS_IDLE;
      ptr_q   <= '0;
      try_q   <= '0;
      req_q   <= 1'b0;
    end else begin
      case (state_q)
        PS_IDLE: begin
          // request strobes are only taken here
          if (poll_req_i || (auto_mode && pause_zero)) begin
            state_q <= PS_SCAN;
            ptr_q   <= '0;
            try_q   <= '0;
          end
        end
        PS_SCAN: begin
          if (pass_end) begin
            state_q <= PS_IDLE;
          end else if (!en_mask_i[ptr_q[CH_W-1:0]]) begin
            ptr_q <= ptr_q + 1'b1;
          end else if (gap_ok) begin
            req_q   <= 1'b1;
            state_q <= PS_READ;
          end
        end
        PS_READ: begin
          if (rd_done_i) begin
            req_q   <= 1'b0;
            state_q <= PS_SCAN;
            if (!rd_err_i || last_try) begin
              ptr_q <= ptr_q + 1'b1;
              try_q <= '0;
            end else begin
              try_q <= try_q + 1'b1;
            end
          end
        end
        default: state_q <= PS_IDLE;
      endcase
    end
  end

  assign rd_req_o = req_q;
  assign rd_ch_o  = ptr_q[CH_W-1:0];
  assign busy_o   = (state_q != PS_IDLE);

  poll_timer #(.GAP_TICKS(GAP_TICKS), .PAUSE_W(PAUSE_W)) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .rd_fin_i     (rd_fin),
    .pause_load_i (pass_end),
    .pause_val_i  (pause_val),
    .gap_ok_o     (gap_ok),
    .pause_zero_o (pause_zero)
  );

  poll_chan_store #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_ch_i    (ptr_q[CH_W-1:0]),
    .wr_fail_i  (rd_err_i),
    .wr_data_i  (rd_data_i),
    .en_mask_i  (en_mask_i),
    .qry_ch_i   (qry_ch_i),
    .qry_data_o (qry_data_o)
  );

  // R2
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_done_i) |=> (rd_req_o && $stable(rd_ch_o)));
  // R2
  idle_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !rd_req_o);
  // R1
  req_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_req_o) |-> $past(en_mask_i[rd_ch_o]));
  // R4
  retry_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_fin && rd_err_i && last_try) |=> (try_q == '0));
endmodule

// File: tb/poll_sched_tb.sv
module poll_sched_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, tick = 0;
  logic [7:0]  en_mask = 0;
  logic [2:0]  dly_code = 0;
  logic [7:0]  retry_lim = 8'd3;
  logic        poll_req = 0;
  logic        rd_req, rd_done = 0, rd_err = 0, busy;
  logic [2:0]  rd_ch, qry_ch = 0;
  logic [15:0] rd_data = 0, qry_data;

  int checks = 0, errors = 0, cyc = 0;
  int tick_div = 0, lat = 0;
  int fail_left [8];
  int att [8];
  int log_ch [64];
  int log_n = 0;
  int since_done = 0, last_gap = 0, min_gap = 1000000, req_rises = 0;
  bit seen_done = 0, req_prev = 0, done_flag = 0;
  logic [15:0] data_base = 16'hE000;

  always #(CLK_PERIOD/2) clk = ~clk;

  poll_sched u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .en_mask_i(en_mask),
    .dly_code_i(dly_code), .retry_lim_i(retry_lim), .poll_req_i(poll_req),
    .rd_req_o(rd_req), .rd_ch_o(rd_ch), .rd_done_i(rd_done), .rd_err_i(rd_err),
    .rd_data_i(rd_data), .qry_ch_i(qry_ch), .qry_data_o(qry_data), .busy_o(busy)
  );

  // tick source, read-engine model and gap monitor
  always @(negedge clk) begin
    cyc++;
    tick = (tick_div == 0) ? 1'b1 : ((cyc % tick_div) == 0);
    if (tick) since_done++;
    if (rd_req && !req_prev) begin
      req_rises++;
      if (seen_done) begin
        last_gap = since_done;
        if (since_done < min_gap) min_gap = since_done;
      end
    end
    req_prev = rd_req;
    if (rd_done) begin
      rd_done = 0;
      rd_err  = 0;
    end else if (rd_req) begin
      lat++;
      if (lat >= 2) begin
        lat = 0;
        att[rd_ch]++;
        if (log_n < 64) log_ch[log_n] = rd_ch;
        log_n++;
        if (fail_left[rd_ch] > 0) begin
          fail_left[rd_ch]--;
          rd_err  = 1;
          rd_data = 16'h80AA;
        end else begin
          rd_err  = 0;
          rd_data = data_base | 16'(rd_ch);
        end
        rd_done    = 1;
        since_done = 0;
        seen_done  = 1;
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected < 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_counts();
    for (int i = 0; i < 8; i++) begin att[i] = 0; fail_left[i] = 0; end
    log_n = 0;
  endtask

  task automatic pulse_req();
    @(negedge clk) poll_req = 1;
    @(negedge clk) poll_req = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic query(input int ch, output logic [15:0] v);
    @(negedge clk) qry_ch = 3'(ch);
    #1 v = qry_data;
  endtask

  task automatic test_reset();
    logic [15:0] v;
    chk(rd_req == 0 && busy == 0, "R2 reset idle", {rd_req, busy}, 0);
    en_mask = 8'h00;
    query(3, v);
    chk(v == 16'h8101, "R6 disabled after reset", v, 16'h8101);
    en_mask = 8'hFF;
    query(3, v);
    chk(v == 16'h8102, "R7 not yet polled", v, 16'h8102);
    repeat (20) @(negedge clk);
    chk(busy == 0, "R10 code 0 no auto pass", busy, 0);
  endtask

  task automatic test_order();
    logic [15:0] v;
    clear_counts();
    en_mask = 8'b0010_0101;
    pulse_req();
    wait_idle();
    chk(log_n == 3, "R1 reads per pass", log_n, 3);
    chk(log_ch[0] == 0 && log_ch[1] == 2 && log_ch[2] == 5, "R1 order",
        log_ch[0]*256 + log_ch[1]*16 + log_ch[2], 16'h025);
    query(0, v);
    chk(v == 16'hE000, "R8 ch0 data", v, 16'hE000);
    query(5, v);
    chk(v == 16'hE005, "R8 ch5 data", v, 16'hE005);
    query(1, v);
    chk(v == 16'h8101, "R6 ch1 disabled", v, 16'h8101);
    en_mask = 8'b0010_0100;
    query(0, v);
    chk(v == 16'h8101, "R6 disable hides stored data", v, 16'h8101);
  endtask

  task automatic test_retry();
    logic [15:0] v;
    clear_counts();
    en_mask   = 8'b0010_0101;
    retry_lim = 8'd3;
    fail_left[2] = 2;
    fail_left[5] = 9;
    data_base = 16'hD100;
    pulse_req();
    wait_idle();
    chk(att[2] == 3, "R4 recover before limit", att[2], 3);
    chk(att[5] == 4, "R4 limit 3 gives 4 tries", att[5], 4);
    query(2, v);
    chk(v == 16'hD102, "R8 data after retries", v, 16'hD102);
    query(5, v);
    chk(v == 16'h8100, "R5 retries exhausted", v, 16'h8100);
    chk(min_gap >= 5, "R3 minimum gap ticks", min_gap, 5);
  endtask

  task automatic test_lim0();
    logic [15:0] v;
    clear_counts();
    en_mask   = 8'h01;
    retry_lim = 8'd0;
    fail_left[0] = 1;
    pulse_req();
    wait_idle();
    chk(att[0] == 1, "R4 limit 0 single try", att[0], 1);
    query(0, v);
    chk(v == 16'h8100, "R5 limit 0 exhausted", v, 16'h8100);
    pulse_req();
    wait_idle();
    query(0, v);
    chk(v == 16'hD100, "R8 recovers next pass", v, 16'hD100);
    retry_lim = 8'd3;
  endtask

  task automatic test_ignore();
    int n0;
    clear_counts();
    en_mask = 8'hFF;
    pulse_req();
    repeat (12) @(negedge clk);
    chk(busy == 1, "R10 pass running", busy, 1);
    pulse_req();
    wait_idle();
    n0 = log_n;
    repeat (60) @(negedge clk);
    chk(busy == 0, "R11 no extra pass", busy, 0);
    chk(log_n == 8 && n0 == 8, "R11 one pass of reads", log_n, 8);
  endtask

  task automatic test_pause(input logic [2:0] code, input int exp);
    int r0, guard;
    clear_counts();
    en_mask  = 8'h01;
    tick_div = 4;
    dly_code = code;
    r0 = req_rises;
    guard = 0;
    while (req_rises < r0 + 2 && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    chk(last_gap >= exp && last_gap <= exp + 4, "R9 pause ticks", last_gap, exp);
  endtask

  task automatic test_code7();
    int r0;
    wait_idle();
    dly_code = 3'd7;
    r0 = req_rises;
    repeat (6000) @(negedge clk);
    chk(req_rises == r0 && busy == 0, "R10 code 7 no auto pass", req_rises - r0, 0);
    pulse_req();
    wait_idle();
    chk(req_rises == r0 + 1, "R10 code 7 request pass", req_rises - r0, 1);
  endtask

  initial begin
    clear_counts();
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    test_reset();
    test_order();
    test_retry();
    test_lim0();
    test_ignore();
    test_pause(3'd1, 5);
    test_pause(3'd4, 100);
    test_pause(3'd6, 1000);
    test_code7();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule